// File: doc/BRIEF.md
# I2C Target with Host-Paced Clock Holding

This block is the target (responder) end of a two-wire I2C bus with a fixed 7-bit own address that the host sets on a port. It samples the clock and data lines through a short synchronizer and finds START and STOP conditions. After each START it collects the address byte. It acknowledges only its own address. It then either collects bytes written by the controller into a one-byte receive buffer, or sends bytes that the local host has placed in the transmit buffer.

For reads, the target holds the clock line low between bytes until the host writes the next byte and pulses `release_set`. This gives the host as long as it needs to service the buffer. Several sticky status outputs report bus events and errors:

- START and STOP seen
- buffer full
- receive overflow
- write collision
- a general event flag

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset, both line drivers are released (`scl_drive_low`=0, `sda_drive_low`=0). All status outputs read 0, and the release bit is set.
- R2: A START (SDA falling while SCL is high) sets `start_seen` and clears `stop_seen`. A STOP (SDA rising while SCL is high) sets `stop_seen` and clears `start_seen`.
- R3: The first byte after a START is sent MSB first and holds the address in bits 7..1. Bit 0 is the direction: 0 means the controller writes, 1 means it reads. The target drives SDA low during the ninth clock only when bits 7..1 equal `own_addr`. On a mismatch it acknowledges no further byte until the next START.
- R4: In write mode, each completed byte appears on `rx_data` and sets `buf_full`, and the target acknowledges it. A `rx_rd` pulse clears `buf_full`.
- R5: A written byte that completes while `buf_full` is 1 sets `rx_overflow`. That byte is not acknowledged, and `rx_data` keeps the earlier byte.
- R6: After acknowledging a read address, the target holds SCL low until `release_set` is pulsed. It then sends the byte loaded through `tx_wr`/`tx_data`, MSB first. `buf_full` is 1 between the load and the end of that byte.
- R7: When the controller acknowledges a sent byte (SDA low on the ninth clock), the target holds SCL low again and waits for the next release. When the controller does not acknowledge (SDA high), the target releases both lines and ignores further clocks until STOP or START.
- R8: A `tx_wr` pulse while a byte is being sent (released, mid-byte) sets `wr_collision` and does not change the bits on the line.
- R9: `event_flag` sets on an address match and on each byte completion that needs host service. A `flags_clr` pulse clears `event_flag`, `rx_overflow` and `wr_collision`.
- R10: A repeated START in the middle of a transfer restarts address collection, and a matching address is then acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock holding) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit address |
| tx_wr | input | 1 | Pulse: load `tx_data` into the transmit buffer |
| tx_data | input | 8 | Byte to send |
| release_set | input | 1 | Pulse: set the release bit, freeing SCL |
| rx_rd | input | 1 | Pulse: host has taken `rx_data` |
| flags_clr | input | 1 | Pulse: clear event, overflow and collision flags |
| rx_data | output | 8 | Last accepted written byte |
| buf_full | output | 1 | Buffer holds an unread or unsent byte |
| start_seen | output | 1 | A START was the latest bus condition |
| stop_seen | output | 1 | A STOP was the latest bus condition |
| rx_overflow | output | 1 | Sticky receive overflow |
| wr_collision | output | 1 | Sticky write collision |
| event_flag | output | 1 | Sticky service request |
| is_read | output | 1 | Direction bit of the last matching address |

## Verification
The hardest state to reach is a host write that lands in the middle of an outgoing byte after the release. That needs a matched read address, a held clock, a host load and release, and then a partly clocked byte. The bench's controller model therefore takes a bit index at which it injects a `tx_wr` between two clock pulses. It then checks that the byte still arrives unchanged. The NACK exit is reached the same way: a read is ended deliberately, and nine extra clocks follow in which SDA must stay released.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_IGNORE
   } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_line_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else        q <= {q[STAGES-2:0], din};
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slv_core.sv
module i2c_slv_core
   import i2c_slv_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              tx_wr,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              release_set,
   input  logic              rx_rd,
   input  logic              flags_clr,
   output logic              sda_low,
   output logic              scl_low,
   output logic [BYTE_W-1:0] rx_data,
   output logic              buf_full,
   output logic              start_seen,
   output logic              stop_seen,
   output logic              rx_overflow,
   output logic              wr_collision,
   output logic              event_flag,
   output logic              is_read
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

   slv_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rx_sh_q, tx_sh_q;
   logic              release_q, ack_drv_q, mack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cnt_q        <= '0;
         rx_sh_q      <= '0;
         tx_sh_q      <= '1;
         release_q    <= 1'b1;
         ack_drv_q    <= 1'b0;
         mack_q       <= 1'b1;
         rx_data      <= '0;
         buf_full     <= 1'b0;
         start_seen   <= 1'b0;
         stop_seen    <= 1'b0;
         rx_overflow  <= 1'b0;
         wr_collision <= 1'b0;
         event_flag   <= 1'b0;
         is_read      <= 1'b0;
      end else begin
         // host side
         if (release_set) release_q <= 1'b1;
         if (rx_rd)       buf_full  <= 1'b0;
         if (flags_clr) begin
            rx_overflow  <= 1'b0;
            wr_collision <= 1'b0;
            event_flag   <= 1'b0;
         end
         if (tx_wr) begin
            if (state_q == ST_TX && release_q) wr_collision <= 1'b1;
            else begin
               tx_sh_q  <= tx_data;
               buf_full <= 1'b1;
            end
         end
         // bus side
         if (start_det) begin
            state_q    <= ST_ADDR;
            cnt_q      <= '0;
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
            release_q  <= 1'b1;
         end else if (stop_det) begin
            state_q    <= ST_IDLE;
            stop_seen  <= 1'b1;
            start_seen <= 1'b0;
            release_q  <= 1'b1;
         end else begin
            case (state_q)
               ST_ADDR, ST_RX: begin
                  if (scl_rise && cnt_q != FULL_BYTE) begin
                     rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_s};
                     cnt_q   <= cnt_q + 1'b1;
                  end
                  if (scl_fall && cnt_q == FULL_BYTE) begin
                     if (state_q == ST_ADDR) begin
                        if (rx_sh_q[BYTE_W-1:1] == own_addr) begin
                           state_q    <= ST_ADDR_ACK;
                           is_read    <= rx_sh_q[0];
                           event_flag <= 1'b1;
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end else begin
                        state_q <= ST_RX_ACK;
                        if (buf_full) begin
                           rx_overflow <= 1'b1;
                           ack_drv_q   <= 1'b0;
                        end else begin
                           rx_data    <= rx_sh_q;
                           buf_full   <= 1'b1;
                           ack_drv_q  <= 1'b1;
                           event_flag <= 1'b1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  cnt_q <= '0;
                  if (is_read) begin
                     state_q   <= ST_TX;
                     release_q <= 1'b0;
                  end else begin
                     state_q <= ST_RX;
                  end
               end
               ST_RX_ACK: if (scl_fall) begin
                  state_q   <= ST_RX;
                  cnt_q     <= '0;
                  ack_drv_q <= 1'b0;
               end
               ST_TX: if (scl_fall) begin
                  tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b1};
                  cnt_q   <= cnt_q + 1'b1;
                  if (cnt_q == LAST_BIT) begin
                     state_q  <= ST_TX_ACK;
                     buf_full <= 1'b0;
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) mack_q <= sda_s;
                  if (scl_fall) begin
                     if (!mack_q) begin
                        state_q    <= ST_TX;
                        cnt_q      <= '0;
                        release_q  <= 1'b0;
                        event_flag <= 1'b1;
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_low = (state_q == ST_ADDR_ACK) |
                    ((state_q == ST_RX_ACK) & ack_drv_q) |
                    ((state_q == ST_TX) & ~tx_sh_q[BYTE_W-1]);
   assign scl_low = ~release_q;
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch
   import i2c_slv_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              tx_wr,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              release_set,
   input  logic              rx_rd,
   input  logic              flags_clr,
   output logic [BYTE_W-1:0] rx_data,
   output logic              buf_full,
   output logic              start_seen,
   output logic              stop_seen,
   output logic              rx_overflow,
   output logic              wr_collision,
   output logic              event_flag,
   output logic              is_read
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] line_raw, line_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   assign line_raw = {sda_i, scl_i};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_sync
         i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[i]),
            .dout (line_s[i])
         );
      end
   endgenerate

   i2c_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (line_s[0]),
      .sda_s    (line_s[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_slv_core u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .sda_s       (line_s[1]),
      .own_addr    (own_addr),
      .tx_wr       (tx_wr),
      .tx_data     (tx_data),
      .release_set (release_set),
      .rx_rd       (rx_rd),
      .flags_clr   (flags_clr),
      .sda_low     (sda_drive_low),
      .scl_low     (scl_drive_low),
      .rx_data     (rx_data),
      .buf_full    (buf_full),
      .start_seen  (start_seen),
      .stop_seen   (stop_seen),
      .rx_overflow (rx_overflow),
      .wr_collision(wr_collision),
      .event_flag  (event_flag),
      .is_read     (is_read)
   );
endmodule

// File: rtl/i2c_slave_stretch_chk.sv
module i2c_slave_stretch_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic tx_wr,
   input logic release_set,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic buf_full,
   input logic start_seen,
   input logic stop_seen,
   input logic rx_overflow,
   input logic wr_collision
);
   p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_seen && stop_seen));

   p_sda_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drive_low != $past(sda_drive_low)) |-> !scl_i);

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overflow) |-> buf_full);

   p_hold_begins_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> !scl_i);

   p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      release_set |=> !scl_drive_low);

   p_collision_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_collision) |-> $past(tx_wr));
endmodule

bind i2c_slave_stretch i2c_slave_stretch_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_i        (scl_i),
   .tx_wr        (tx_wr),
   .release_set  (release_set),
   .scl_drive_low(scl_drive_low),
   .sda_drive_low(sda_drive_low),
   .buf_full     (buf_full),
   .start_seen   (start_seen),
   .stop_seen    (stop_seen),
   .rx_overflow  (rx_overflow),
   .wr_collision (wr_collision)
);

// File: tb/sim_i2c_slave_stretch.sv
module sim_i2c_slave_stretch;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_dl, sda_dl;
   logic [6:0] own_addr = 7'h3A;
   logic tx_wr = 1'b0, release_set = 1'b0, rx_rd = 1'b0, flags_clr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic [7:0] rx_data;
   logic buf_full, start_seen, stop_seen, rx_overflow, wr_collision, event_flag, is_read;
   logic scl_ln, sda_ln;
   int checks = 0, errors = 0, cycles = 0;

   always #2 clk = ~clk;

   assign scl_ln = scl_m & ~scl_dl;
   assign sda_ln = sda_m & ~sda_dl;

   i2c_slave_stretch u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
      .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .own_addr(own_addr),
      .tx_wr(tx_wr), .tx_data(tx_data), .release_set(release_set),
      .rx_rd(rx_rd), .flags_clr(flags_clr), .rx_data(rx_data),
      .buf_full(buf_full), .start_seen(start_seen), .stop_seen(stop_seen),
      .rx_overflow(rx_overflow), .wr_collision(wr_collision),
      .event_flag(event_flag), .is_read(is_read)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog: act=hung exp=done");
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tx(input logic [7:0] d);
      tx_data = d; tx_wr = 1'b1; wc(1); tx_wr = 1'b0; wc(1);
   endtask
   task automatic pulse_rel();
      release_set = 1'b1; wc(1); release_set = 1'b0; wc(1);
   endtask
   task automatic pulse_rd();
      rx_rd = 1'b1; wc(1); rx_rd = 1'b0; wc(1);
   endtask
   task automatic pulse_clr();
      flags_clr = 1'b1; wc(1); flags_clr = 1'b0; wc(1);
   endtask

   task automatic clk_bit(input logic b, output logic got);
      sda_m = b; wc(H);
      scl_m = 1'b1; wc(1);
      while (!scl_ln) wc(1);
      wc(H);
      got = sda_ln;
      scl_m = 1'b0; wc(H);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; wc(H);
      sda_m = 1'b0; wc(H);
      scl_m = 1'b0; wc(H);
   endtask

   task automatic bus_restart();
      sda_m = 1'b1; wc(H);
      scl_m = 1'b1; wc(H);
      sda_m = 1'b0; wc(H);
      scl_m = 1'b0; wc(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wc(H);
      scl_m = 1'b1; wc(1);
      while (!scl_ln) wc(1);
      wc(H);
      sda_m = 1'b1; wc(H);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic g;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], g);
      clk_bit(1'b1, g);
      ack = ~g;
   endtask

   // collide_at < 8 injects a host write before that bit index is clocked
   task automatic recv_byte(input logic ack, input int collide_at, output logic [7:0] d);
      logic g;
      for (int i = 7; i >= 0; i--) begin
         if (i == collide_at) pulse_tx(8'hFF);
         clk_bit(1'b1, g);
         d[i] = g;
      end
      clk_bit(~ack, g);
   endtask

   initial begin
      logic ack, g;
      logic [7:0] d;
      wc(3);
      // R1: reset state
      chk("R1 scl drive", scl_dl, 0);
      chk("R1 sda drive", sda_dl, 0);
      chk("R1 flags", {buf_full, start_seen, stop_seen, rx_overflow, wr_collision, event_flag}, 0);
      rst_n = 1'b1;
      wc(4);

      // R3: address sweep for two own addresses
      for (int k = 0; k < 2; k++) begin
         own_addr = (k == 0) ? 7'h3A : 7'h45;
         for (int a = 0; a < 128; a++) begin
            bus_start();
            if (a == 0) chk("R2 start_seen after START", {start_seen, stop_seen}, 2'b10);
            send_byte({a[6:0], 1'b0}, ack);
            chk("R3 ack iff address match", ack, (a[6:0] == own_addr) ? 1 : 0);
            bus_stop();
            if (a == 0) chk("R2 stop_seen after STOP", {start_seen, stop_seen}, 2'b01);
         end
      end
      own_addr = 7'h3A;
      pulse_clr();
      chk("R9 flags cleared", {event_flag, rx_overflow, wr_collision}, 0);

      // R4, R5, R9: write path and overflow
      bus_start();
      send_byte({own_addr, 1'b0}, ack);
      chk("R3 write address ack", ack, 1);
      chk("R9 event on match", event_flag, 1);
      chk("R3 direction write", is_read, 0);
      pulse_clr();
      send_byte(8'h11, ack);
      chk("R4 byte ack", ack, 1);
      chk("R4 rx_data", rx_data, 8'h11);
      chk("R4 buf_full set", buf_full, 1);
      chk("R9 event on byte", event_flag, 1);
      send_byte(8'h22, ack);
      chk("R5 overflow byte nacked", ack, 0);
      chk("R5 overflow flag", rx_overflow, 1);
      chk("R5 rx_data kept", rx_data, 8'h11);
      pulse_rd();
      chk("R4 rx_rd clears buf_full", buf_full, 0);
      pulse_clr();
      chk("R9 clear overflow", rx_overflow, 0);
      send_byte(8'h33, ack);
      chk("R4 next byte ack", ack, 1);
      chk("R4 next rx_data", rx_data, 8'h33);
      pulse_rd();
      bus_stop();

      // R3, R10: mismatch ignored, repeated start recovers
      pulse_clr();
      bus_start();
      send_byte({own_addr ^ 7'h01, 1'b0}, ack);
      chk("R3 mismatch no ack", ack, 0);
      send_byte(8'h55, ack);
      chk("R3 byte after mismatch no ack", ack, 0);
      chk("R3 nothing stored after mismatch", {buf_full, event_flag, rx_data}, {2'b00, 8'h33});
      bus_restart();
      send_byte({own_addr, 1'b0}, ack);
      chk("R10 restart address ack", ack, 1);
      send_byte(8'h66, ack);
      chk("R10 byte after restart", {ack, rx_data}, {1'b1, 8'h66});
      pulse_rd();
      bus_stop();

      // R6, R7, R8: read path
      pulse_clr();
      bus_start();
      send_byte({own_addr, 1'b1}, ack);
      chk("R6 read address ack", ack, 1);
      chk("R3 direction read", is_read, 1);
      chk("R6 holds SCL", scl_dl, 1);
      scl_m = 1'b1; wc(30);
      chk("R6 SCL still low while held", scl_ln, 0);
      scl_m = 1'b0; wc(2);
      pulse_tx(8'hA5);
      chk("R6 buf_full after load", buf_full, 1);
      pulse_rel();
      chk("R6 release frees SCL", scl_dl, 0);
      recv_byte(1'b1, 99, d);
      chk("R6 first byte MSB first", d, 8'hA5);
      chk("R6 buf_full cleared after byte", buf_full, 0);
      chk("R7 holds after master ack", scl_dl, 1);
      pulse_tx(8'h3C);
      pulse_rel();
      chk("R8 no collision before shifting", wr_collision, 0);
      recv_byte(1'b0, 3, d);
      chk("R8 collision flagged", wr_collision, 1);
      chk("R8 byte unchanged by collision", d, 8'h3C);
      chk("R7 lines free after nack", {scl_dl, sda_dl}, 0);
      for (int i = 0; i < 9; i++) begin
         clk_bit(1'b1, g);
         chk("R7 SDA released after nack", g, 1);
      end
      bus_stop();
      pulse_clr();
      chk("R9 clear collision", wr_collision, 0);

      summary();
      $finish;
   end
endmodule